// File: doc/BRIEF.md
# Cubic Edge-Enhancement Pixel Pipeline

This block sharpens a grey-scale image one pixel at a time. Each clock it takes a centre pixel and its four direct neighbours (above, below, left, right) as 8-bit unsigned values. It first forms a signed high-pass value, four times the centre minus the sum of the neighbours. It then cubes that value, so that weak texture stays nearly untouched while strong edges are pushed hard.

The cube is scaled down by an arithmetic right shift, which rounds toward negative infinity. The result is clipped to a signed 9-bit correction and added to the centre pixel. The sum is saturated to the 0..255 pixel range.

The datapath is fully pipelined. It takes a new neighbourhood on every cycle, never stalls, and returns each result exactly five cycles later. A valid flag travels alongside the data. An upstream window extractor feeds the five pixels, and a downstream consumer takes the output pixel whenever the output valid flag is high.

Top module: `cubic_sharpen`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on the first edge after it, `out_valid` is 0 and `out_pix` is 0.
- R2: `out_valid` equals the value `in_valid` had exactly 5 rising edges earlier. The latency is fixed and does not depend on the pixel values.
- R3: When all five input pixels are equal, the output pixel equals the centre pixel.
- R4: The correction is computed as follows. Form L = 4·c − n − s − e − w. Take L³ and shift it right arithmetically by SHIFT bits (default 12), rounding toward negative infinity. For example, with c=100, L=−1 gives 99, L=15 gives 100 and L=16 gives 101.
- R5: Before the addition, the shifted correction is clipped to the range −256..255. A correction of +3375 therefore acts as +255, and −2600 acts as −256. It is never wrapped to 9 bits.
- R6: The sum of the clipped correction and the zero-extended centre is saturated. Sums below 0 give 0 and sums above 255 give 255. For example, c=255 with L=16 gives 255, and c=0 with L=−16 gives 0.
- R7: A new input set is accepted on every cycle. Back-to-back distinct inputs produce back-to-back outputs in the same order, each one 5 cycles after its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the five input pixels as a real sample |
| in_c | input | PIX_W | Centre pixel, unsigned |
| in_n | input | PIX_W | Pixel above the centre |
| in_s | input | PIX_W | Pixel below the centre |
| in_e | input | PIX_W | Pixel right of the centre |
| in_w | input | PIX_W | Pixel left of the centre |
| out_valid | output | 1 | Marks `out_pix` as the result of a valid input set |
| out_pix | output | PIX_W | Enhanced, saturated pixel |

## Verification
The checker watches four things on every cycle:
- the quiet output in the cycle after reset;
- the exact five-cycle delay of the valid flag;
- the flat-region identity;
- the sign relation that follows from the cube. A non-negative high-pass value never darkens the pixel, and a non-positive one never brightens it.

Only the bench's chosen scenarios can show the exact arithmetic: the floor rounding of the shift at the −1, 15 and 16 thresholds, clipping instead of wrapping of large corrections, and saturation at both ends of the pixel range. They are compared every cycle against a behavioural model, under both gapped and back-to-back valid patterns.

// File: rtl/cubic_sharpen_pkg.sv
package cubic_sharpen_pkg;

    localparam int DEF_PIX_W = 8;
    localparam int DEF_SHIFT = 12;

    // Saturate a signed integer into [lo, hi].
    function automatic int clip_int(input int x, input int lo, input int hi);
        if (x < lo)
            return lo;
        else if (x > hi)
            return hi;
        else
            return x;
    endfunction

endpackage

// File: rtl/cubic_sharpen_lap.sv
module cubic_sharpen_lap #(
    parameter int PIX_W = 8,
    parameter int LAP_W = PIX_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [PIX_W-1:0]        c_i,
    input  logic [PIX_W-1:0]        n_i,
    input  logic [PIX_W-1:0]        s_i,
    input  logic [PIX_W-1:0]        e_i,
    input  logic [PIX_W-1:0]        w_i,
    output logic                    vld_o,
    output logic [PIX_W-1:0]        ctr_o,
    output logic signed [LAP_W-1:0] lap_o
);
    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] ctr;
        logic [LAP_W-1:0] lap;
    } st_t;

    st_t st_d, st_q;

    logic signed [LAP_W-1:0] cx, nx, sx, ex, wx;

    always_comb begin
        cx = $signed(LAP_W'(c_i));
        nx = $signed(LAP_W'(n_i));
        sx = $signed(LAP_W'(s_i));
        ex = $signed(LAP_W'(e_i));
        wx = $signed(LAP_W'(w_i));
        st_d.vld = vld_i;
        st_d.ctr = c_i;
        st_d.lap = (cx <<< 2) - nx - sx - ex - wx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign ctr_o = st_q.ctr;
    assign lap_o = $signed(st_q.lap);
endmodule

// File: rtl/cubic_sharpen_cube.sv
module cubic_sharpen_cube #(
    parameter int PIX_W  = 8,
    parameter int LAP_W  = PIX_W + 3,
    parameter int CUBE_W = 3 * (LAP_W - 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [PIX_W-1:0]         ctr_i,
    input  logic signed [LAP_W-1:0]  lap_i,
    output logic                     vld_o,
    output logic [PIX_W-1:0]         ctr_o,
    output logic signed [CUBE_W-1:0] cube_o
);
    typedef struct packed {
        logic              vld;
        logic [PIX_W-1:0]  ctr;
        logic [CUBE_W-1:0] cube;
    } st_t;

    st_t st_d, st_q;

    logic signed [CUBE_W-1:0] lx;

    always_comb begin
        lx = CUBE_W'(lap_i);
        st_d.vld  = vld_i;
        st_d.ctr  = ctr_i;
        st_d.cube = lx * lx * lx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign ctr_o  = st_q.ctr;
    assign cube_o = $signed(st_q.cube);
endmodule

// File: rtl/cubic_sharpen_squash.sv
module cubic_sharpen_squash
    import cubic_sharpen_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int SHIFT  = 12,
    parameter int CUBE_W = 31,
    parameter int LIM_W  = PIX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [PIX_W-1:0]         ctr_i,
    input  logic signed [CUBE_W-1:0] cube_i,
    output logic                     vld_o,
    output logic [PIX_W-1:0]         ctr_o,
    output logic signed [LIM_W-1:0]  term_o
);
    localparam int TERM_HI = (1 << PIX_W) - 1;
    localparam int TERM_LO = -(1 << PIX_W);

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] ctr;
        logic [LIM_W-1:0] term;
    } st_t;

    st_t st_d, st_q;

    logic signed [CUBE_W-1:0] scaled;

    always_comb begin
        scaled    = cube_i >>> SHIFT;
        st_d.vld  = vld_i;
        st_d.ctr  = ctr_i;
        st_d.term = LIM_W'(clip_int(int'(scaled), TERM_LO, TERM_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign ctr_o  = st_q.ctr;
    assign term_o = $signed(st_q.term);
endmodule

// File: rtl/cubic_sharpen_merge.sv
module cubic_sharpen_merge
    import cubic_sharpen_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LIM_W = PIX_W + 1,
    parameter int SUM_W = PIX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [PIX_W-1:0]        ctr_i,
    input  logic signed [LIM_W-1:0] term_i,
    output logic                    vld_o,
    output logic [PIX_W-1:0]        pix_o
);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        logic             sum_vld;
        logic [SUM_W-1:0] sum;
        logic             out_vld;
        logic [PIX_W-1:0] pix;
    } st_t;

    st_t st_d, st_q;

    logic signed [SUM_W-1:0] term_x;
    logic signed [SUM_W-1:0] ctr_x;

    always_comb begin
        term_x       = SUM_W'(term_i);
        ctr_x        = $signed(SUM_W'(ctr_i));
        st_d.sum_vld = vld_i;
        st_d.sum     = term_x + ctr_x;
        st_d.out_vld = st_q.sum_vld;
        st_d.pix     = PIX_W'(clip_int(int'($signed(st_q.sum)), 0, PIX_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o = st_q.out_vld;
    assign pix_o = st_q.pix;
endmodule

// File: rtl/cubic_sharpen.sv
module cubic_sharpen
    import cubic_sharpen_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int SHIFT = DEF_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_c,
    input  logic [PIX_W-1:0] in_n,
    input  logic [PIX_W-1:0] in_s,
    input  logic [PIX_W-1:0] in_e,
    input  logic [PIX_W-1:0] in_w,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam int LAP_W  = PIX_W + 3;
    localparam int CUBE_W = 3 * (LAP_W - 1) + 1;
    localparam int LIM_W  = PIX_W + 1;
    localparam int SUM_W  = PIX_W + 2;

    logic                     v1, v2, v3;
    logic [PIX_W-1:0]         c1, c2, c3;
    logic signed [LAP_W-1:0]  lap1;
    logic signed [CUBE_W-1:0] cube2;
    logic signed [LIM_W-1:0]  term3;

    cubic_sharpen_lap #(.PIX_W(PIX_W), .LAP_W(LAP_W)) u_lap (
        .clk(clk), .rst_n(rst_n), .vld_i(in_valid),
        .c_i(in_c), .n_i(in_n), .s_i(in_s), .e_i(in_e), .w_i(in_w),
        .vld_o(v1), .ctr_o(c1), .lap_o(lap1)
    );

    cubic_sharpen_cube #(.PIX_W(PIX_W), .LAP_W(LAP_W), .CUBE_W(CUBE_W)) u_cube (
        .clk(clk), .rst_n(rst_n), .vld_i(v1), .ctr_i(c1), .lap_i(lap1),
        .vld_o(v2), .ctr_o(c2), .cube_o(cube2)
    );

    cubic_sharpen_squash #(.PIX_W(PIX_W), .SHIFT(SHIFT), .CUBE_W(CUBE_W), .LIM_W(LIM_W)) u_squash (
        .clk(clk), .rst_n(rst_n), .vld_i(v2), .ctr_i(c2), .cube_i(cube2),
        .vld_o(v3), .ctr_o(c3), .term_o(term3)
    );

    cubic_sharpen_merge #(.PIX_W(PIX_W), .LIM_W(LIM_W), .SUM_W(SUM_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .vld_i(v3), .ctr_i(c3), .term_i(term3),
        .vld_o(out_valid), .pix_o(out_pix)
    );
endmodule

// File: rtl/cubic_sharpen_chk.sv
module cubic_sharpen_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_c,
    input logic [PIX_W-1:0] in_n,
    input logic [PIX_W-1:0] in_s,
    input logic [PIX_W-1:0] in_e,
    input logic [PIX_W-1:0] in_w,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);
    // Edges seen since reset release, saturating at the pipeline depth.
    logic [2:0] since_rst;
    int         hp_now;
    logic       flat_now;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd5)
            since_rst <= since_rst + 3'd1;
    end

    always_comb begin
        hp_now   = 4 * int'(in_c) - int'(in_n) - int'(in_s) - int'(in_e) - int'(in_w);
        flat_now = (in_c == in_n) && (in_c == in_s) && (in_c == in_e) && (in_c == in_w);
        warm     = (since_rst == 3'd5);
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_pix == '0));

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 5)));

    a_r3_flat_passes_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(flat_now, 5)) |-> (out_pix == $past(in_c, 5)));

    // R4: the cube keeps the sign of the high-pass value
    a_r4_no_darken: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hp_now, 5) >= 0) |-> (out_pix >= $past(in_c, 5)));

    a_r4_no_brighten: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hp_now, 5) <= 0) |-> (out_pix <= $past(in_c, 5)));
endmodule

bind cubic_sharpen cubic_sharpen_chk #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_c(in_c), .in_n(in_n), .in_s(in_s), .in_e(in_e), .in_w(in_w),
    .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/cubic_sharpen_bench.sv
module cubic_sharpen_bench;
    localparam int PERIOD = 10;
    localparam int PW     = 8;
    localparam int SH     = 12;
    localparam int DEPTH  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_c = '0, in_n = '0, in_s = '0, in_e = '0, in_w = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;

    int checks = 0;
    int fails  = 0;
    int    q_pix[$];
    bit    q_vld[$];
    string q_tag[$];

    cubic_sharpen #(.PIX_W(PW), .SHIFT(SH)) u_cubic_sharpen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_c(in_c), .in_n(in_n), .in_s(in_s), .in_e(in_e), .in_w(in_w),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int model(int c, int n, int s, int e, int w);
        longint hp, cube, sc, sum;
        hp   = 4 * c - n - s - e - w;
        cube = hp * hp * hp;
        sc   = cube >>> SH;
        if (sc > 255) sc = 255;
        if (sc < -256) sc = -256;
        sum = sc + c;
        if (sum < 0) sum = 0;
        if (sum > 255) sum = 255;
        return int'(sum);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one input set, clock once, compare with the model's value queued DEPTH-1 ticks earlier.
    task automatic tick(bit v, int c, int n, int s, int e, int w, string tag);
        int    ep;
        bit    ev;
        string et;
        in_valid = v;
        in_c = PW'(c); in_n = PW'(n); in_s = PW'(s); in_e = PW'(e); in_w = PW'(w);
        q_pix.push_back(model(c, n, s, e, w));
        q_vld.push_back(v);
        q_tag.push_back(tag);
        @(posedge clk);
        #(PERIOD/4);
        ep = q_pix.pop_front();
        ev = q_vld.pop_front();
        et = q_tag.pop_front();
        check(et, int'(out_valid), int'(ev), "out_valid");
        check(et, int'(out_pix), ep, "out_pix");
    endtask

    task automatic flush(string tag);
        for (int i = 0; i < DEPTH; i++) tick(1'b0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lf;
        // R1: reset state
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check("R1", int'(out_valid), 0, "out_valid in reset");
        check("R1", int'(out_pix), 0, "out_pix in reset");
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++) begin
            q_pix.push_back(0); q_vld.push_back(1'b0); q_tag.push_back("R1");
        end

        // R3: flat regions
        tick(1, 0, 0, 0, 0, 0, "R3");
        tick(1, 77, 77, 77, 77, 77, "R3");
        tick(1, 255, 255, 255, 255, 255, "R3");
        tick(1, 128, 128, 128, 128, 128, "R3");
        flush("R3");

        // R4: floor rounding thresholds
        tick(1, 100, 101, 100, 100, 100, "R4");   // hp = -1  -> 99
        tick(1, 100, 85, 100, 100, 100, "R4");    // hp = 15  -> 100
        tick(1, 100, 84, 100, 100, 100, "R4");    // hp = 16  -> 101
        tick(1, 100, 115, 100, 100, 100, "R4");   // hp = -15 -> 99
        tick(1, 60, 50, 55, 65, 40, "R4");
        flush("R4");

        // R5: clip instead of wrap
        tick(1, 100, 40, 40, 40, 40, "R5");       // +3375 -> +255
        tick(1, 200, 255, 255, 255, 255, "R5");   // -2600 -> -256
        flush("R5");

        // R6: output saturation
        tick(1, 255, 251, 251, 251, 251, "R6");   // 256 -> 255
        tick(1, 0, 4, 4, 4, 4, "R6");             // -1 -> 0
        tick(1, 255, 0, 0, 0, 0, "R6");
        tick(1, 0, 255, 255, 255, 255, "R6");
        flush("R6");

        // R2: gapped valid pattern
        for (int i = 0; i < 16; i++)
            tick(((i % 3) == 0) || ((i % 5) == 1), 30 + i, 20, 40 + i, 35, 25, "R2");
        flush("R2");

        // R7: back-to-back varied pixels
        lf = 32'h1ace;
        for (int i = 0; i < 40; i++) begin
            int c, n, s, e, w;
            lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
            c = (lf >> 3) & 255; n = (lf >> 11) & 255; s = (lf >> 19) & 255;
            e = ((lf >> 7) ^ (lf >> 17)) & 255; w = (c + (i * 37)) & 255;
            tick(1, c, n, s, e, w, "R7");
        end
        flush("R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule